// File: doc/BRIEF.md
# Four-Channel Programmable Down-Counter Timer

This block holds four independent down-counting timer channels behind a word-addressed 32-bit register port. Each channel has a load value, a live count, a control byte and a reload value that is used at the next wrap. Software starts a channel by writing its load value and then its control byte. It can read the live count at any time and turn it into a rising time base by inverting or negating it. When a channel counts from one down to zero it flags an interrupt. A shared group of registers (mask, raw status, masked status, clear) merges the four flags into one interrupt line.

Each channel is a three-state machine. `CH_IDLE` is the stopped state. `CH_COUNT` decrements once per prescaled tick. `CH_SPENT` holds a finished one-shot at zero. The machine has four named transitions:
- *enable*: IDLE to COUNT, on a control write with the enable bit set.
- *expire*: COUNT to SPENT, when a one-shot channel reaches zero.
- *rearm*: SPENT to COUNT, on a load write while the channel is enabled.
- *disable*: any state to IDLE, on a control write with the enable bit clear.

The timer clock is the bus clock.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every count, reload value, control byte, raw status bit and mask bit is zero, and `irq_out` is low.
- R2: A load write (channel offset +0x0) puts its data into the live count and the reload value on the same edge, including 0xFFFFFFFF, and wins over a decrement in that cycle. A reload write (+0xC) changes only the reload value.
- R3: Control bits 3:2 pick the tick rate: 00 every cycle, 01 every 16 cycles, 10 or 11 every 256 cycles. The first decrement falls 1, 16 or 256 cycles after the enabling control write. The prescaler restarts from zero whenever the channel is not counting.
- R4: Free-running mode (control bit 6 and bit 0 both clear): a tick at zero wraps the count to all ones of the active width.
- R5: Periodic mode (bit 6 set, bit 0 clear): a tick at zero reloads the count from the reload value.
- R6: One-shot mode (bit 0 set, whatever bit 6 holds): the count stops at zero and raises its flag once. Nothing more happens until the next load write, which restarts counting from the new value.
- R7: With control bit 1 clear only the low 16 bits count and wrap, and the count reads with its upper 16 bits zero. With bit 1 set all 32 bits count.
- R8: Raw status bit n (offset 0x04) is set on the edge where channel n counts from 1 to 0, whatever the mask. Writing 1 to bit n of the clear register (0x0C) clears it. If a clear and a new event hit the same edge, the bit stays set.
- R9: The mask register (0x00) holds bit n for channel n. Masked status (0x08) is raw AND mask. `irq_out` is high exactly when some masked bit is set.
- R10: A control write (+0x8) with bit 7 clear stops the channel at once. The cycle of any control write does not decrement the count.
- R11: Channel n sits at 0x10 + 0x10*n. A read strobe returns data on `bus_rdata` after the next edge, and the data holds until the next read. Unmapped or misaligned addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | OR of the masked interrupt bits |

## Verification
Two functions can land on the same edge: a channel's zero event setting its raw bit, and a software write to the clear register. The bench reloads a free-running channel with 2, spends one cycle on a read, and issues the clear write on exactly the edge where the count reaches zero. The raw status read that follows must still show the bit, and unmasking it must then raise `irq_out`. A similar collision, a load write landing on a counting channel, is judged by reading back the written value rather than a decremented one.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_e;

    localparam int CTL_W     = 8;
    localparam int CTL_EN    = 7;
    localparam int CTL_PER   = 6;
    localparam int CTL_PRE   = 2;
    localparam int CTL_WIDE  = 1;
    localparam int CTL_ONE   = 0;

    localparam int OFS_MASK  = 'h00;
    localparam int OFS_RAW   = 'h04;
    localparam int OFS_MIS   = 'h08;
    localparam int OFS_CLR   = 'h0C;

    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h10;
    localparam int CH_LOAD   = 'h0;
    localparam int CH_VAL    = 'h4;
    localparam int CH_CTL    = 'h8;
    localparam int CH_BG     = 'hC;

endpackage

// File: rtl/qdt_prescaler.sv
module qdt_prescaler #(
    parameter int DIV_MID = 16,
    parameter int DIV_MAX = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] code,
    output logic       tick
);
    localparam int PC_W = $clog2(DIV_MAX);
    localparam logic [PC_W-1:0] LIM_ONE = '0;
    localparam logic [PC_W-1:0] LIM_MID = PC_W'(DIV_MID - 1);
    localparam logic [PC_W-1:0] LIM_MAX = PC_W'(DIV_MAX - 1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] lim;

    always_comb begin
        unique case (code)
            2'b00:   lim = LIM_ONE;
            2'b01:   lim = LIM_MID;
            default: lim = LIM_MAX;
        endcase
    end

    assign tick = run && (pc_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pc_q <= '0;
        else if (!run)   pc_q <= '0;
        else if (tick)   pc_q <= '0;
        else             pc_q <= pc_q + 1'b1;
    end

    // R3
    pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pc_q == '0));

endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16,
    parameter int DIV_MID  = 16,
    parameter int DIV_MAX  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ld_we,
    input  logic             bg_we,
    input  logic             ctrl_we,
    output logic [CNT_W-1:0] value_o,
    output logic [CNT_W-1:0] bg_o,
    output logic [CTL_W-1:0] ctrl_o,
    output logic             evt_o
);
    localparam logic [CNT_W-1:0] NAR_MASK =
        {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, bg_q;
    logic [CTL_W-1:0] ctrl_q, ctrl_nx;
    logic [CNT_W-1:0] cnt_eff, bg_eff, ones;
    logic             wide, tick, evt;

    assign ctrl_nx = ctrl_we ? wdata[CTL_W-1:0] : ctrl_q;
    assign wide    = ctrl_q[CTL_WIDE];
    assign cnt_eff = wide ? cnt_q : (cnt_q & NAR_MASK);
    assign bg_eff  = wide ? bg_q  : (bg_q  & NAR_MASK);
    assign ones    = wide ? {CNT_W{1'b1}} : NAR_MASK;

    qdt_prescaler #(.DIV_MID(DIV_MID), .DIV_MAX(DIV_MAX)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q == CH_COUNT),
        .code (ctrl_q[CTL_PRE+1:CTL_PRE]),
        .tick (tick)
    );

    // next state and count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        evt   = 1'b0;
        unique case (st_q)
            CH_IDLE: begin
                if (ctrl_nx[CTL_EN]) st_d = CH_COUNT;
            end
            CH_COUNT: begin
                if (!ctrl_nx[CTL_EN]) begin
                    st_d = CH_IDLE;
                end else if (tick && !ctrl_we && !ld_we) begin
                    if (cnt_eff == '0) begin
                        if (ctrl_q[CTL_ONE]) begin
                            st_d = CH_SPENT;
                            evt  = 1'b1;
                        end else if (ctrl_q[CTL_PER]) begin
                            cnt_d = bg_eff;
                        end else begin
                            cnt_d = ones;
                        end
                    end else begin
                        cnt_d = cnt_eff - CNT_W'(1);
                        if (cnt_eff == CNT_W'(1)) begin
                            evt = 1'b1;
                            if (ctrl_q[CTL_ONE]) st_d = CH_SPENT;
                        end
                    end
                end
            end
            CH_SPENT: begin
                if (!ctrl_nx[CTL_EN]) st_d = CH_IDLE;
                else if (ld_we)       st_d = CH_COUNT;
            end
            default: st_d = CH_IDLE;
        endcase
        if (ld_we) cnt_d = wdata;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bg_q   <= '0;
            ctrl_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            ctrl_q <= ctrl_nx;
            if (ld_we || bg_we) bg_q <= wdata;
        end
    end

    // outputs
    always_comb begin
        value_o = cnt_eff;
        bg_o    = bg_q;
        ctrl_o  = ctrl_q;
        evt_o   = evt;
    end

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_COUNT && tick && !ctrl_we && !ld_we && cnt_eff > CNT_W'(1))
        |=> (cnt_eff == $past(cnt_eff) - CNT_W'(1)));

    // R6
    spent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_SPENT && !ld_we && !ctrl_we) |=> $stable(cnt_q));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_IDLE && !ld_we) |=> $stable(cnt_q));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> (cnt_q == $past(wdata) && bg_q == $past(wdata)));

endmodule

// File: rtl/qdt_irq_ctrl.sv
module qdt_irq_ctrl #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_i,
    input  logic           mask_we,
    input  logic           clr_we,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] mis_o,
    output logic           irq_o
);
    logic [NCH-1:0] raw_q, mask_q, clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | evt_i;
            if (mask_we) mask_q <= wdata;
        end
    end

    assign raw_o  = raw_q;
    assign mask_o = mask_q;
    assign mis_o  = raw_q & mask_q;
    assign irq_o  = |mis_o;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R8
        raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> raw_q[i]);
        // R8
        raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wdata[i] && !evt_i[i]) |=> !raw_q[i]);
        // R8
        raw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw_q[i]) |-> $past(evt_i[i]));
    end

endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
    import qdt_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int DIV_MID  = 16,
    parameter int DIV_MAX  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MIS  = ADDR_W'(OFS_MIS);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

    logic [DATA_W-1:0] ch_val [NUM_CH];
    logic [DATA_W-1:0] ch_bg  [NUM_CH];
    logic [CTL_W-1:0]  ch_ctl [NUM_CH];
    logic [NUM_CH-1:0] ch_evt;
    logic [NUM_CH-1:0] raw, mask, mis;
    logic [DATA_W-1:0] rd_mux [NUM_CH+1];

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_LD  = ADDR_W'(CH_BASE + CH_STRIDE*n + CH_LOAD);
        localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(CH_BASE + CH_STRIDE*n + CH_VAL);
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CH_BASE + CH_STRIDE*n + CH_CTL);
        localparam logic [ADDR_W-1:0] A_BG  = ADDR_W'(CH_BASE + CH_STRIDE*n + CH_BG);

        qdt_channel #(
            .CNT_W   (DATA_W),
            .NARROW_W(NARROW_W),
            .DIV_MID (DIV_MID),
            .DIV_MAX (DIV_MAX)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wdata  (bus_wdata),
            .ld_we  (bus_we && bus_addr == A_LD),
            .bg_we  (bus_we && bus_addr == A_BG),
            .ctrl_we(bus_we && bus_addr == A_CTL),
            .value_o(ch_val[n]),
            .bg_o   (ch_bg[n]),
            .ctrl_o (ch_ctl[n]),
            .evt_o  (ch_evt[n])
        );

        always_comb begin
            if      (bus_addr == A_LD || bus_addr == A_BG) rd_mux[n+1] = ch_bg[n];
            else if (bus_addr == A_VAL)                    rd_mux[n+1] = ch_val[n];
            else if (bus_addr == A_CTL)                    rd_mux[n+1] = DATA_W'(ch_ctl[n]);
            else                                           rd_mux[n+1] = rd_mux[n];
        end
    end

    qdt_irq_ctrl #(.NCH(NUM_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (ch_evt),
        .mask_we(bus_we && bus_addr == A_MASK),
        .clr_we (bus_we && bus_addr == A_CLR),
        .wdata  (bus_wdata[NUM_CH-1:0]),
        .raw_o  (raw),
        .mask_o (mask),
        .mis_o  (mis),
        .irq_o  (irq_out)
    );

    always_comb begin
        unique case (bus_addr)
            A_MASK:  rd_mux[0] = DATA_W'(mask);
            A_RAW:   rd_mux[0] = DATA_W'(raw);
            A_MIS:   rd_mux[0] = DATA_W'(mis);
            default: rd_mux[0] = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux[NUM_CH];
    end

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    // R9
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_out);

endmodule

// File: tb/quad_down_timer_test.sv
module quad_down_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    logic rd_pend = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    quad_down_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [7:0] ch_a(input int n, input int ofs);
        return 8'(16 + 16*n + ofs);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // monitor: pops expected read data
    always @(posedge clk) rd_pend <= bus_re;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) check("SB", bus_rdata, 32'hDEAD_BEEF);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog got %0d exp <20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_re = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        rd(8'h04, 32'h0, "R1 raw");
        rd(8'h00, 32'h0, "R1 mask");
        rd(ch_a(0, 4), 32'h0, "R1 val");
        rd(ch_a(0, 8), 32'h0, "R1 ctrl");

        // R6 one-shot (bit6 also set: bit0 decides), R3 div1
        wr(ch_a(0, 0), 32'd3);
        wr(ch_a(0, 8), 32'hC3);
        rd(ch_a(0, 4), 32'd3, "R3 dec");
        rd(ch_a(0, 4), 32'd2, "R3 dec");
        rd(ch_a(0, 4), 32'd1, "R3 dec");
        rd(ch_a(0, 4), 32'd0, "R6 zero");
        rd(8'h04, 32'h1, "R8 raw set");
        idle(4);
        rd(ch_a(0, 4), 32'd0, "R6 stopped");
        check("R9 masked irq", {31'b0, irq_out}, 32'h0);
        wr(8'h0C, 32'h1);
        rd(8'h04, 32'h0, "R8 clear");
        idle(3);
        rd(8'h04, 32'h0, "R6 single flag");
        wr(ch_a(0, 0), 32'd2);
        rd(ch_a(0, 4), 32'd2, "R6 rearm");
        rd(ch_a(0, 4), 32'd1, "R6 rearm");
        rd(8'h04, 32'h1, "R6 rearm flag");
        rd(ch_a(0, 4), 32'd0, "R6 rearm stop");

        // R9 mask and masked status
        wr(8'h00, 32'h1);
        check("R9 irq high", {31'b0, irq_out}, 32'h1);
        rd(8'h08, 32'h1, "R9 mis");
        rd(8'h00, 32'h1, "R9 mask rd");
        wr(8'h00, 32'h0);
        check("R9 irq low", {31'b0, irq_out}, 32'h0);
        rd(8'h08, 32'h0, "R9 mis off");
        rd(8'h04, 32'h1, "R8 raw kept");
        wr(8'h0C, 32'h1);

        // R5 periodic, R2 reload write, R10 stop
        wr(ch_a(1, 0), 32'd2);
        wr(ch_a(1, 12), 32'd5);
        rd(ch_a(1, 12), 32'd5, "R2 bg");
        rd(ch_a(1, 4), 32'd2, "R2 bg no disturb");
        wr(ch_a(1, 8), 32'hC2);
        rd(ch_a(1, 4), 32'd2, "R5 per");
        rd(ch_a(1, 4), 32'd1, "R5 per");
        rd(ch_a(1, 4), 32'd0, "R5 per");
        rd(ch_a(1, 4), 32'd5, "R5 reload");
        rd(ch_a(1, 4), 32'd4, "R5 reload");
        rd(8'h04, 32'h2, "R8 ch1");
        wr(ch_a(1, 8), 32'h00);
        rd(ch_a(1, 4), 32'd2, "R10 stop");
        idle(3);
        rd(ch_a(1, 4), 32'd2, "R10 stop");

        // R7 narrow width, R4 free-running wrap
        wr(ch_a(2, 0), 32'h0001_0002);
        wr(ch_a(2, 8), 32'h80);
        rd(ch_a(2, 4), 32'd2, "R7 narrow rd");
        rd(ch_a(2, 4), 32'd1, "R7 narrow");
        rd(ch_a(2, 4), 32'd0, "R7 narrow");
        rd(ch_a(2, 4), 32'h0000_FFFF, "R4 R7 wrap16");
        rd(ch_a(2, 4), 32'h0000_FFFE, "R4 R7 wrap16");
        rd(8'h04, 32'h6, "R8 ch2");

        // R4 wide wrap, R2 full value load while running
        wr(ch_a(3, 0), 32'd1);
        wr(ch_a(3, 8), 32'h82);
        rd(ch_a(3, 4), 32'd1, "R4 wide");
        rd(ch_a(3, 4), 32'd0, "R4 wide");
        rd(ch_a(3, 4), 32'hFFFF_FFFF, "R4 wrap32");
        wr(ch_a(3, 0), 32'hFFFF_FFFF);
        rd(ch_a(3, 4), 32'hFFFF_FFFF, "R2 full load");
        rd(ch_a(3, 4), 32'hFFFF_FFFE, "R2 full load");
        rd(ch_a(3, 12), 32'hFFFF_FFFF, "R2 bg copy");

        // R3 prescale 16 and 256 (code 11), prescaler restart
        wr(ch_a(3, 8), 32'h00);
        wr(ch_a(3, 0), 32'd3);
        wr(ch_a(3, 8), 32'h86);
        rd(ch_a(3, 4), 32'd3, "R3 div16");
        idle(14);
        rd(ch_a(3, 4), 32'd3, "R3 div16 hold");
        rd(ch_a(3, 4), 32'd2, "R3 div16 step");
        wr(ch_a(3, 8), 32'h00);
        wr(ch_a(3, 0), 32'd2);
        wr(ch_a(3, 8), 32'h8E);
        rd(ch_a(3, 4), 32'd2, "R3 div256");
        idle(254);
        rd(ch_a(3, 4), 32'd2, "R3 div256 hold");
        rd(ch_a(3, 4), 32'd1, "R3 div256 step");
        wr(ch_a(3, 8), 32'h00);

        // R8 clear and event on the same edge
        wr(8'h0C, 32'hF);
        wr(ch_a(2, 0), 32'd2);
        rd(ch_a(2, 4), 32'd2, "R8 collide prep");
        wr(8'h0C, 32'h4);
        rd(8'h04, 32'h4, "R8 set wins");
        wr(8'h00, 32'h4);
        check("R9 irq ch2", {31'b0, irq_out}, 32'h1);
        rd(8'h08, 32'h4, "R9 mis ch2");

        // R11 unmapped, misaligned, hold
        rd(8'h50, 32'h0, "R11 unmapped");
        rd(8'h11, 32'h0, "R11 misaligned");
        rd(ch_a(1, 8), 32'h0, "R11 ctrl rd");
        idle(3);
        check("R11 hold", bus_rdata, 32'h0);
        rd(ch_a(1, 12), 32'd5, "R11 bg rd");
        idle(3);
        check("R11 hold", bus_rdata, 32'd5);

        idle(2);
        if (exp_q.size() != 0) check("SB drain", 32'(exp_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule